// File: doc/BRIEF.md
# Device Interrupt Request and Priority Mask Flag Logic

This block is the interrupt side of one peripheral controller on a shared I/O bus. It keeps two flags. The first is a completion flag, set when the device finishes an operation. The second is a disable flag, loaded from the processor's broadcast priority mask. While the completion flag is set and the disable flag is clear, the block drives a level interrupt request toward the processor.

The processor samples that request at the start of every memory cycle. The block keeps the result of the last sample as a "waiting" flag, which tells whether this device is now queued for an interrupt. The request stays up until one of two things happens: the program clears the completion flag with a clear or start command, or a mask word with this device's bit set arrives. Either event also drops the waiting flag at once. A mask that clears the disable flag while the completion flag is still set brings the request back, and the device queues again at the next memory-cycle sample.

Every device listens to one fixed bit of the 16-bit mask word, chosen by a parameter. Several devices may share one bit. A mask word of zero re-enables every device.

Top module: `dev_irq_mask`

## Requirements
- R1: After reset, the completion flag, disable flag, request and waiting outputs are all 0.
- R2: A completion pulse sets the completion flag at the next clock edge. The request output is 1 exactly while the completion flag is 1 and the disable flag is 0.
- R3: A clear command or a start command clears the completion flag at the next edge, and this wins over a completion pulse in the same cycle. The request and waiting outputs drop at that same edge.
- R4: On an edge with the memory-cycle-start strobe high, the waiting output takes the value the request output had before that edge. Without the strobe, waiting never rises, and it holds while the request stays up.
- R5: On an edge with the mask strobe high, the disable flag takes data bus bit MASK_BIT. The other bus bits, and the whole bus without the strobe, have no effect.
- R6: When the disable flag becomes 1, the request and waiting outputs are 0 from that same edge, even if a memory-cycle-start strobe falls in that cycle.
- R7: When a mask clears the disable flag while the completion flag is 1, the request returns at that edge. Waiting returns only at the next sampled memory-cycle start.
- R8: A mask word of all zeros clears the disable flag.
- R9: While disabled, a completion pulse still sets the completion flag but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneSet | input | 1 | Device completion pulse |
| cmdClear | input | 1 | Program clear command (clears completion flag) |
| cmdStart | input | 1 | Program start command (clears completion flag) |
| maskStrobe | input | 1 | Mask-out broadcast strobe |
| dataBus | input | DATA_W | Broadcast data bus carrying the mask word |
| cycleStart | input | 1 | Memory-cycle-start sampling strobe |
| doneFlag | output | 1 | Completion flag |
| disableFlag | output | 1 | Interrupt disable flag |
| intReq | output | 1 | Level interrupt request |
| intWait | output | 1 | Synchronized waiting flag |

## Verification
The bench builds the block with MASK_BIT = 9 and the default 16-bit bus. Mask words then exercise set and clear bits on both sides of the selected position, and a bus bit that leaks into the disable flag shows up as a mismatch. A long pseudo-random walk drives every combination of the five strobes together with varied bus words, starting from all four flag states. This reaches the corner cases: clear against completion in one cycle, disable against a sample in one cycle, and re-enable with a pending completion. Directed sequences then check reset, withdrawal, restoration and the zero mask on their own.

// File: rtl/dev_irq_pkg.sv
package dev_irq_pkg;
  typedef struct packed {
    logic setDone;
    logic clrDone;
    logic loadMask;
    logic sample;
  } irqStrobes_t;
endpackage

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl
  import dev_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        doneSet,
  input  logic        cmdClear,
  input  logic        cmdStart,
  input  logic        maskStrobe,
  input  logic        cycleStart,
  output irqStrobes_t strb
);
  logic clrAny;

  // Either program command empties the completion flag; it beats a completion pulse (R3)
  always_comb begin
    clrAny        = cmdClear | cmdStart;
    strb.clrDone  = clrAny;
    strb.setDone  = doneSet & ~clrAny;
    strb.loadMask = maskStrobe;
    strb.sample   = cycleStart;
  end

  p_clr_beats_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneSet && cmdClear) |-> !strb.setDone);
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> strb.clrDone);
endmodule

// File: rtl/dev_irq_dp.sv
module dev_irq_dp
  import dev_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MASK_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strb,
  input  logic [DATA_W-1:0] dataBus,
  output logic              doneFlag,
  output logic              disableFlag,
  output logic              intReq,
  output logic              intWait
);
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << MASK_BIT;

  logic doneQ, disQ, waitQ;
  logic doneNext, disNext, reqNext, waitNext;
  logic maskBit;

  // Pick the assigned bit of the broadcast word
  assign maskBit = |(dataBus & SEL_MASK);

  always_comb begin
    doneNext = doneQ;
    if (strb.clrDone)      doneNext = 1'b0;
    else if (strb.setDone) doneNext = 1'b1;
    disNext  = strb.loadMask ? maskBit : disQ;
    reqNext  = doneNext & ~disNext;
    // Capture the current level at a cycle start; any withdrawal kills it now
    waitNext = (strb.sample ? intReq : waitQ) & reqNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      disQ  <= 1'b0;
      waitQ <= 1'b0;
    end else begin
      doneQ <= doneNext;
      disQ  <= disNext;
      waitQ <= waitNext;
    end
  end

  assign doneFlag    = doneQ;
  assign disableFlag = disQ;
  assign intReq      = doneQ & ~disQ;
  assign intWait     = waitQ;

  p_reset_r1: assert property (@(posedge clk) !rstN |=> (!doneQ && !disQ && !waitQ));
  p_done_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> doneQ);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDone |=> (!doneQ && !intWait));
  p_wait_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    intWait |-> intReq);
  p_no_rise_unsampled_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sample && !waitQ) |=> !waitQ);
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMask |=> (disQ == $past(dataBus[MASK_BIT])));
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMask |=> $stable(disQ));
  p_withdraw_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disQ) |-> (!intWait && !intReq));
  p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadMask && dataBus == '0) |=> !disQ);
endmodule

// File: rtl/dev_irq_mask.sv
module dev_irq_mask
  import dev_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MASK_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doneSet,
  input  logic              cmdClear,
  input  logic              cmdStart,
  input  logic              maskStrobe,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              cycleStart,
  output logic              doneFlag,
  output logic              disableFlag,
  output logic              intReq,
  output logic              intWait
);
  irqStrobes_t strb;

  dev_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .doneSet(doneSet), .cmdClear(cmdClear),
    .cmdStart(cmdStart), .maskStrobe(maskStrobe), .cycleStart(cycleStart),
    .strb(strb)
  );

  dev_irq_dp #(.DATA_W(DATA_W), .MASK_BIT(MASK_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataBus(dataBus),
    .doneFlag(doneFlag), .disableFlag(disableFlag),
    .intReq(intReq), .intWait(intWait)
  );
endmodule

// File: tb/dev_irq_mask_tb.sv
module dev_irq_mask_tb;
  localparam int DW = 16;
  localparam int MB = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doneSet = 0, cmdClear = 0, cmdStart = 0, maskStrobe = 0, cycleStart = 0;
  logic [DW-1:0] dataBus = '0;
  logic doneFlag, disableFlag, intReq, intWait;

  int total = 0;
  int bad = 0;
  logic mDone = 0, mDis = 0, mWait = 0;

  always #2 clk = ~clk;

  dev_irq_mask #(.DATA_W(DW), .MASK_BIT(MB)) u_dut (
    .clk(clk), .rstN(rstN), .doneSet(doneSet), .cmdClear(cmdClear),
    .cmdStart(cmdStart), .maskStrobe(maskStrobe), .dataBus(dataBus),
    .cycleStart(cycleStart), .doneFlag(doneFlag), .disableFlag(disableFlag),
    .intReq(intReq), .intWait(intWait)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, advance the expected model, check after the edge
  task automatic step(input logic ds, input logic cc, input logic cs,
                      input logic ms, input logic [DW-1:0] d, input logic cy);
    logic nDone, nDis, curReq, nReq;
    @(negedge clk);
    doneSet = ds; cmdClear = cc; cmdStart = cs; maskStrobe = ms;
    dataBus = d; cycleStart = cy;
    curReq = mDone & ~mDis;
    nDone  = (cc | cs) ? 1'b0 : (ds ? 1'b1 : mDone);
    nDis   = ms ? d[MB] : mDis;
    nReq   = nDone & ~nDis;
    mWait  = (cy ? curReq : mWait) & nReq;
    mDone  = nDone;
    mDis   = nDis;
    @(posedge clk); #1;
    chk("R2 done", doneFlag, mDone);
    chk("R5 disable", disableFlag, mDis);
    chk("R2 request", intReq, mDone & ~mDis);
    chk("R4 waiting", intWait, mWait);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 done", doneFlag, 1'b0);
    chk("R1 disable", disableFlag, 1'b0);
    chk("R1 request", intReq, 1'b0);
    chk("R1 waiting", intWait, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // R2/R4: completion, then sample
    step(1, 0, 0, 0, '0, 0);
    chk("R2 request up", intReq, 1'b1);
    chk("R4 not yet waiting", intWait, 1'b0);
    step(0, 0, 0, 0, '0, 1);
    chk("R4 waiting after sample", intWait, 1'b1);
    step(0, 0, 0, 0, '0, 0);
    chk("R4 waiting holds", intWait, 1'b1);

    // R6: disable with a sample in the same cycle
    step(0, 0, 0, 1, 16'h0200, 1);
    chk("R6 request withdrawn", intReq, 1'b0);
    chk("R6 waiting withdrawn", intWait, 1'b0);
    // R9: completion while disabled
    step(1, 0, 0, 0, '0, 1);
    chk("R9 done recorded", doneFlag, 1'b1);
    chk("R9 no request", intReq, 1'b0);
    // R5: strobe with other bits set, selected bit clear -> enables
    step(0, 0, 0, 1, 16'hFDFF, 0);
    chk("R5 other bits ignored", disableFlag, 1'b0);
    // R7: request returns, waiting only after a sample
    chk("R7 request restored", intReq, 1'b1);
    chk("R7 not waiting yet", intWait, 1'b0);
    step(0, 0, 0, 0, 16'hFFFF, 0);
    chk("R5 bus ignored without strobe", disableFlag, 1'b0);
    step(0, 0, 0, 0, '0, 1);
    chk("R7 waiting after sample", intWait, 1'b1);
    // R3: clear against completion in one cycle
    step(1, 1, 0, 0, '0, 1);
    chk("R3 clear wins", doneFlag, 1'b0);
    chk("R3 waiting dropped", intWait, 1'b0);
    step(1, 0, 0, 0, '0, 0);
    step(0, 0, 1, 0, '0, 0);
    chk("R3 start clears", doneFlag, 1'b0);
    // R8: zero mask after disable
    step(0, 0, 0, 1, 16'h0200, 0);
    step(0, 0, 0, 1, 16'h0000, 0);
    chk("R8 zero mask enables", disableFlag, 1'b0);

    // Walk each single-bit mask word through the strobe (R5)
    for (int b = 0; b < DW; b++) begin
      step(0, 0, 0, 1, DW'(1) << b, 0);
      chk("R5 single bit", disableFlag, (b == MB) ? 1'b1 : 1'b0);
    end

    // Pseudo-random walk over all strobe combinations (R2..R9 via model)
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = {lfsr[7:0], lfsr[15:8]} ^ DW'(i * 40503);
      step(lfsr[0], lfsr[1] & lfsr[5], lfsr[2] & lfsr[6] & lfsr[9],
           lfsr[3] & lfsr[7], w, lfsr[4]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule